// File: doc/BRIEF.md
# Modem Line Control and Status Register Pair

This block keeps the modem-side state of a serial port. A five-bit control register drives four handshake outputs and a loopback switch. An eight-bit status register holds the current level of four incoming modem lines in its upper half. Its lower half holds sticky change flags. The incoming lines come from outside the clock domain. Each passes through a two-flop synchronizer before it is compared with the stored level.

Software reaches both registers through a byte-wide port that has a single select bit. Reading the status register acknowledges the change flags. While any flag is set, a level-sensitive event output is high, and a separate interrupt arbiter can use it. With loopback on, a status read returns the control outputs, rearranged into the upper status positions, in place of the external lines.

Top module: `modem_ctl_stat`

## Requirements
- R1: After reset the control register reads 0x08 (only the OUT2 bit set), the status register reads 0xB0, and `msr_event` is low.
- R2: A write with `reg_sel`=0 stores `wdata[4:0]` into the control register, with bit 4 loopback, 3 OUT2, 2 OUT1, 1 RTS and 0 DTR. `wdata[7:5]` is dropped and reads back as zero. The outputs `loop_on`, `out2_out`, `out1_out`, `rts_out` and `dtr_out` follow these bits from the next cycle.
- R3: Status bits 7..4 are DCD, RI, DSR and CTS. A level change on an input shows in these bits on the third rising edge after the change, once it has passed two synchronizer flops and the status register.
- R4: Status bit 3 (DCD changed), bit 1 (DSR changed) and bit 0 (CTS changed) are set when the stored level of that line changes in either direction. Each stays set until it is cleared by R6.
- R5: Status bit 2 is set only when the stored RI level falls from 1 to 0. A rise of RI leaves it unchanged.
- R6: A status read (`reg_rd`=1, `reg_sel`=1) with loopback off returns the current value. From the next cycle bits 3..0 read zero, unless R7 applies. Bits 7..4 are not affected.
- R7: If a flag-clearing read and a new level change fall on the same edge, the change flag from that edge is set after the edge.
- R8: `msr_event` is high exactly when any of status bits 3..0 is set.
- R9: With loopback on, a status read returns OUT2 in bit 7, OUT1 in bit 6, DTR in bit 5, RTS in bit 4 and zero in bits 3..0. Such a read does not clear the stored change flags.
- R10: A write with `reg_sel`=1 has no effect on either register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe, one cycle |
| reg_rd | input | 1 | Read strobe, one cycle; used only to acknowledge flags |
| reg_sel | input | 1 | 0 selects control register, 1 selects status register |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the selected register (combinational) |
| cts_in | input | 1 | Clear-to-send line, asynchronous |
| dsr_in | input | 1 | Data-set-ready line, asynchronous |
| dcd_in | input | 1 | Carrier-detect line, asynchronous |
| ri_in | input | 1 | Ring-indicator line, asynchronous |
| rts_out | output | 1 | Request-to-send output |
| dtr_out | output | 1 | Data-terminal-ready output |
| out1_out | output | 1 | General output 1 |
| out2_out | output | 1 | General output 2 |
| loop_on | output | 1 | Loopback mode active |
| msr_event | output | 1 | High while any change flag is set |

## Verification
The assertions assume that `reg_wr` and `reg_rd` are never both high in the same cycle. They also assume that a write or read strobe lasts exactly one cycle. They do not assume that the modem lines are stable for any length of time. The bench keeps to these rules by pulsing a single strobe at a time. It lets the four lines toggle freely, even on consecutive cycles, and in a pseudo-random phase it places reads on the same edges as line changes so that the R7 race is hit often.

// File: rtl/modem_ctl_stat.sv
module modem_ctl_stat (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic       reg_sel,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       cts_in,
  input  logic       dsr_in,
  input  logic       dcd_in,
  input  logic       ri_in,
  output logic       rts_out,
  output logic       dtr_out,
  output logic       out1_out,
  output logic       out2_out,
  output logic       loop_on,
  output logic       msr_event
);
  localparam logic [3:0] LVL_RST = 4'b1011;
  localparam logic [4:0] CTL_RST = 5'b01000;

  logic [3:0] s1, s2, lvl, dl;
  logic [4:0] ctl;

  wire [3:0] pins = {dcd_in, ri_in, dsr_in, cts_in};
  wire [3:0] chg  = s2 ^ lvl;
  wire [3:0] hit  = {chg[3], chg[2] & ~s2[2], chg[1], chg[0]};
  wire       clr  = reg_rd & reg_sel & ~ctl[4];
  wire [2:0] wdata_hi_unused = wdata[7:5];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1  <= LVL_RST;
      s2  <= LVL_RST;
      lvl <= LVL_RST;
      dl  <= '0;
      ctl <= CTL_RST;
    end else begin
      s1  <= pins;
      s2  <= s1;
      lvl <= s2;
      dl  <= (clr ? 4'b0000 : dl) | hit;
      if (reg_wr && !reg_sel) ctl <= wdata[4:0];
    end
  end

  assign {loop_on, out2_out, out1_out, rts_out, dtr_out} = ctl;
  assign msr_event = |dl;

  always_comb begin
    if (!reg_sel)      rdata = {3'b000, ctl};
    else if (ctl[4])   rdata = {ctl[3], ctl[2], ctl[0], ctl[1], 4'b0000};
    else               rdata = {lvl, dl};
  end

  AST_CTL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && !reg_sel |=> {loop_on, out2_out, out1_out, rts_out, dtr_out} == $past(wdata[4:0])); // R2
  AST_STATUS_WR_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_sel |=> $stable({loop_on, out2_out, out1_out, rts_out, dtr_out})); // R10
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(dl) & ~dl) != 4'b0000) |-> $past(clr)); // R4
  AST_RI_RISE_NO_TERI: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lvl[2]) && !$past(dl[2]) |-> !dl[2]); // R5
  AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr) && $stable(lvl) |-> dl == 4'b0000); // R6
  AST_CHANGE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr) && (lvl[0] != $past(lvl[0])) |-> dl[0]); // R7
  AST_EVENT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(msr_event) |-> !$stable(lvl)); // R8
  AST_LOOP_MAP: assert property (@(posedge clk) disable iff (!rst_n)
    loop_on && reg_sel |-> rdata[3:0] == 4'b0000 && rdata[7] == out2_out && rdata[5] == dtr_out); // R9
endmodule

// File: tb/modem_ctl_stat_test.sv
`timescale 1ns/1ps
module modem_ctl_stat_test;
  logic clk = 0, rst_n = 0;
  logic reg_wr = 0, reg_rd = 0, reg_sel = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic cts_in = 1, dsr_in = 1, dcd_in = 1, ri_in = 0;
  logic rts_out, dtr_out, out1_out, out2_out, loop_on, msr_event;

  modem_ctl_stat uut (.*);

  always #2.5 clk = ~clk;

  int n_tests = 0, n_fail = 0;
  string cur_req = "R1";

  logic [4:0] m_ctl;
  logic [3:0] m_up, m_dl;
  logic [3:0] pq[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctl = 5'b01000; m_up = 4'b1011; m_dl = 4'b0000;
      pq = {4'b1011, 4'b1011};
    end else begin
      logic [3:0] np, d;
      logic clr;
      np = pq.pop_front();
      pq.push_back({dcd_in, ri_in, dsr_in, cts_in});
      d = np ^ m_up;
      d[2] = (m_up[2] == 1'b1) && (np[2] == 1'b0);
      clr = reg_rd && reg_sel && !m_ctl[4];
      m_dl = (clr ? 4'b0000 : m_dl) | d;
      m_up = np;
      if (reg_wr && !reg_sel) m_ctl = wdata[4:0];
    end
  end

  task automatic compare();
    logic [7:0] er;
    logic [13:0] act, exp;
    if (!reg_sel) er = {3'b000, m_ctl};
    else if (m_ctl[4]) er = {m_ctl[3], m_ctl[2], m_ctl[0], m_ctl[1], 4'b0000};
    else er = {m_up, m_dl};
    exp = {er, m_ctl, |m_dl};
    act = {rdata, loop_on, out2_out, out1_out, rts_out, dtr_out, msr_event};
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h (rdata,ctl,event)", cur_req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2; compare();
  endtask

  task automatic wr(input logic sel, input logic [7:0] v);
    reg_wr = 1; reg_sel = sel; wdata = v; tick(); reg_wr = 0;
  endtask

  task automatic rd_status();
    reg_rd = 1; reg_sel = 1; tick(); reg_rd = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] lf;
    #12 rst_n = 1;
    // R1: reset values of both registers
    cur_req = "R1";
    reg_sel = 0; tick(); reg_sel = 1; tick();
    // R2: control writes keep five bits
    cur_req = "R2";
    wr(0, 8'hE7); reg_sel = 0; idle(2);
    wr(0, 8'h0A); idle(1);
    // R3 and R4: line changes and sticky flags
    cur_req = "R3"; reg_sel = 1;
    cts_in = 0; idle(4);
    cur_req = "R4";
    dsr_in = 0; idle(2); dsr_in = 1; idle(4);
    dcd_in = 0; idle(5);
    // R6: read clears flags
    cur_req = "R6";
    rd_status(); idle(2);
    // R5: ring indicator edges
    cur_req = "R5";
    ri_in = 1; idle(5); ri_in = 0; idle(5);
    rd_status(); idle(1);
    // R7: change on same edge as clearing read
    cur_req = "R7";
    cts_in = 1; tick(); tick(); rd_status(); idle(3);
    // R8: event follows flags
    cur_req = "R8";
    dcd_in = 1; idle(4); rd_status(); idle(2);
    // R9: loopback mapping, read does not clear
    cur_req = "R9";
    dsr_in = 0; idle(4);
    wr(0, 8'h1A); reg_sel = 1; idle(1);
    rd_status(); idle(1);
    wr(0, 8'h15); reg_sel = 1; idle(1);
    wr(0, 8'h08); reg_sel = 1; idle(2);
    // R10: writes to status ignored
    cur_req = "R10";
    wr(1, 8'hFF); reg_sel = 0; idle(1); reg_sel = 1; idle(1);
    // Mixed pseudo-random phase
    cur_req = "R4";
    lf = 16'hACE1;
    for (int k = 0; k < 400; k++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      {dcd_in, ri_in, dsr_in, cts_in} = lf[3:0] ^ lf[11:8];
      reg_sel = lf[5];
      if (lf[7:6] == 2'b11) begin
        reg_rd = 1; reg_sel = 1;
      end else if (lf[7:4] == 4'b1000) begin
        reg_wr = 1; wdata = {lf[15:12], lf[0], 3'b000} & 8'hEF;
      end
      tick();
      reg_rd = 0; reg_wr = 0;
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule